// File: doc/BRIEF.md
# Strobe-Ordered Refresh Row Selector

This block sits at the row-address front of a dynamic memory core and decides, each time the row strobe goes active, where the row address for that cycle comes from. Both strobes are active low and are sampled on a system clock (they are assumed already synchronised). In an ordinary cycle the row comes from the external address lines. When the column strobe has fallen while the row strobe was still inactive, and is still low when the row strobe falls, the cycle is a refresh-only cycle. That cycle disregards the external address and takes its row from an internal refresh counter, which then advances when the cycle closes.

A controller FSM has four states. PRECHG is row strobe inactive. ROWACC is an ordinary row cycle. CBR_RFSH is refresh only. CTR_TEST is a counter-test access. The transitions are as follows:
- PRECHG→ROWACC: row strobe falls without an armed column strobe.
- PRECHG→CBR_RFSH: row strobe falls while armed and column strobe low.
- CBR_RFSH→CTR_TEST: column strobe falls again inside the refresh.
- ROWACC/CBR_RFSH/CTR_TEST→PRECHG: row strobe rises.

An arm flag is set in PRECHG by a column-strobe falling edge and cleared whenever the FSM leaves PRECHG. The counter-test state lets a later column access reach the counter-derived row, so the counter can be exercised. The counter value is exported for checking.

Top module: `cbr_row_select`

## Requirements
- R1: After synchronous reset the FSM is in PRECHG. `row_sel`, `cnt_value`, `row_strobe`, `refresh_only`, `ctr_test` and `col_en` are all 0.
- R2: Suppose the row strobe is sampled low in PRECHG and no column-strobe fall has been seen in PRECHG. Then one clock later `row_sel` equals `row_addr`, `row_strobe` is 1 for exactly that one cycle, and `refresh_only` is 0.
- R3: Suppose `cas_n` fell (1 then 0 on successive samples) while in PRECHG, and `cas_n` is still 0 when `ras_n` is sampled low. Then one clock later `refresh_only` is 1 and `row_sel` equals `cnt_value`, whatever `row_addr` holds.
- R4: A column strobe that falls in the same sample as the row strobe does not select refresh. Neither does one held low from the previous cycle with no new fall, nor one that rose again before the row strobe fell. In each case the cycle is ordinary and uses `row_addr`.
- R5: The counter advances by exactly 1 on the clock that samples the row strobe high in CBR_RFSH or CTR_TEST. The new value is visible in the same cycle that `refresh_only`/`ctr_test` drop, and the count wraps from 511 to 0.
- R6: Ordinary cycles never change `cnt_value`.
- R7: `col_en` is 1 one clock after `cas_n` is sampled low in ROWACC or CTR_TEST. It is 0 throughout CBR_RFSH and in PRECHG, so a column strobe low while the row strobe is high has no effect on it.
- R8: In CBR_RFSH, a further fall of `cas_n` (after it rose) enters CTR_TEST. `ctr_test` and `col_en` become 1, `refresh_only` becomes 0, and `row_sel` keeps the counter value. The counter still advances only once, at the end of the cycle.
- R9: `row_sel` changes only in the cycle where `row_strobe` is 1.
- R10: At most one of `refresh_only` and `ctr_test` is 1 at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| row_addr | input | 9 | External row address |
| row_sel | output | 9 | Row chosen for the current cycle |
| row_strobe | output | 1 | One-cycle pulse when a new row is latched |
| refresh_only | output | 1 | Current cycle is a refresh-only cycle |
| ctr_test | output | 1 | Current cycle is a counter-test access |
| col_en | output | 1 | Column access path enabled |
| cnt_value | output | 9 | Refresh counter value |

## Verification
The strobe-ordering decision and the start of an ordinary cycle can land in one sample when both strobes fall together. The bench provokes this by dropping `cas_n` and `ras_n` in the same clock from a precharge with the column strobe high. It judges the result by requiring `row_sel` to equal the external address, `refresh_only` to stay 0 and the counter to stay unchanged. The counter advance likewise coincides with the return to precharge; the bench checks that the new count and the dropped flags appear in the same sampled cycle.

// File: rtl/cbr_row_pkg.sv
package cbr_row_pkg;
    localparam int ROW_W = 9;

    typedef enum logic [1:0] {
        PRECHG   = 2'd0,
        ROWACC   = 2'd1,
        CBR_RFSH = 2'd2,
        CTR_TEST = 2'd3
    } row_state_e;
endpackage

// File: rtl/strobe_edge.sv
module strobe_edge #(
    parameter int N = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] sig_n,
    output logic [N-1:0] fell,
    output logic [N-1:0] rose
);
    logic [N-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '1;
        else     prev_q <= sig_n;
    end

    for (genvar i = 0; i < N; i++) begin : g_edge
        assign fell[i] = prev_q[i] & ~sig_n[i];
        assign rose[i] = ~prev_q[i] & sig_n[i];
    end
endmodule

// File: rtl/rfsh_counter.sv
module rfsh_counter #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst)      count <= '0;
        else if (adv) count <= count + 1'b1;
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        !$stable(count) |-> count == $past(count) + 1'b1); // R5
endmodule

// File: rtl/cbr_row_select.sv
module cbr_row_select
    import cbr_row_pkg::*;
#(
    parameter int RW = ROW_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ras_n,
    input  logic          cas_n,
    input  logic [RW-1:0] row_addr,
    output logic [RW-1:0] row_sel,
    output logic          row_strobe,
    output logic          refresh_only,
    output logic          ctr_test,
    output logic          col_en,
    output logic [RW-1:0] cnt_value
);
    localparam int NSTB = 2;

    row_state_e   state, nxt;
    logic         armed;
    logic         cnt_adv;
    logic [NSTB-1:0] fell, rose;
    logic         cas_fell;

    strobe_edge #(.N(NSTB)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .sig_n({cas_n, ras_n}),
        .fell (fell),
        .rose (rose)
    );
    assign cas_fell = fell[1];

    rfsh_counter #(.W(RW)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .adv  (cnt_adv),
        .count(cnt_value)
    );

    always_comb begin
        nxt     = state;
        cnt_adv = 1'b0;
        unique case (state)
            PRECHG: begin
                if (!ras_n) nxt = (armed && !cas_n) ? CBR_RFSH : ROWACC;
            end
            ROWACC: begin
                if (ras_n) nxt = PRECHG;
            end
            CBR_RFSH: begin
                if (ras_n) begin
                    nxt     = PRECHG;
                    cnt_adv = 1'b1;
                end else if (cas_fell) begin
                    nxt = CTR_TEST;
                end
            end
            CTR_TEST: begin
                if (ras_n) begin
                    nxt     = PRECHG;
                    cnt_adv = 1'b1;
                end
            end
            default: nxt = PRECHG;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PRECHG;
            armed <= 1'b0;
        end else begin
            state <= nxt;
            if (nxt != PRECHG)                armed <= 1'b0;
            else if (state == PRECHG && cas_fell) armed <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            row_sel    <= '0;
            row_strobe <= 1'b0;
            col_en     <= 1'b0;
        end else begin
            row_strobe <= (state == PRECHG) && (nxt != PRECHG);
            if (state == PRECHG && nxt == ROWACC)   row_sel <= row_addr;
            if (state == PRECHG && nxt == CBR_RFSH) row_sel <= cnt_value;
            col_en <= ((nxt == ROWACC) || (nxt == CTR_TEST)) && !cas_n;
        end
    end

    assign refresh_only = (state == CBR_RFSH);
    assign ctr_test     = (state == CTR_TEST);

    AST_ONE_MODE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({refresh_only, ctr_test})); // R10
    AST_RFSH_NO_COL: assert property (@(posedge clk) disable iff (rst)
        refresh_only |-> !col_en); // R7
    AST_ROW_HOLD: assert property (@(posedge clk) disable iff (rst)
        !row_strobe |-> $stable(row_sel)); // R9
    AST_CBR_ROW: assert property (@(posedge clk) disable iff (rst)
        $rose(refresh_only) |-> row_sel == cnt_value); // R3
    AST_TEST_AFTER_RFSH: assert property (@(posedge clk) disable iff (rst)
        $rose(ctr_test) |-> $past(refresh_only)); // R8
    AST_ADV_ON_EXIT: assert property (@(posedge clk) disable iff (rst)
        ($fell(refresh_only) && !ctr_test) |-> cnt_value == $past(cnt_value) + 1'b1); // R5
endmodule

// File: tb/tb_cbr_row_select.sv
module tb_cbr_row_select;
    localparam int RW = 9;

    logic          clk = 1'b0;
    logic          rst;
    logic          ras_n, cas_n;
    logic [RW-1:0] row_addr;
    logic [RW-1:0] row_sel, cnt_value;
    logic          row_strobe, refresh_only, ctr_test, col_en;

    int n_chk = 0;
    int n_bad = 0;
    int exp_cnt = 0;

    always #4 clk = ~clk;

    cbr_row_select dut (
        .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n),
        .row_addr(row_addr), .row_sel(row_sel), .row_strobe(row_strobe),
        .refresh_only(refresh_only), .ctr_test(ctr_test), .col_en(col_en),
        .cnt_value(cnt_value)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic precharge();
        ras_n = 1'b1; cas_n = 1'b1; step(); step();
    endtask

    task automatic t_reset();
        rst = 1'b1; ras_n = 1'b1; cas_n = 1'b1; row_addr = '0;
        step(); step();
        rst = 1'b0; step();
        chk("R1 row_sel", row_sel, 0);
        chk("R1 cnt", cnt_value, 0);
        chk("R1 flags", {row_strobe, refresh_only, ctr_test, col_en}, 0);
    endtask

    task automatic t_normal(input int a);
        precharge();
        cas_n = 1'b0; step();
        chk("R7 col idle", col_en, 0);
        cas_n = 1'b1; step();
        cas_n = 1'b1; ras_n = 1'b1; step();
        row_addr = RW'(a); ras_n = 1'b0; step();
        chk("R2 row", row_sel, a);
        chk("R2 strobe", row_strobe, 1);
        chk("R2 rfsh", refresh_only, 0);
        row_addr = RW'(~a); step();
        chk("R2 strobe one cycle", row_strobe, 0);
        chk("R9 hold", row_sel, a);
        cas_n = 1'b0; step();
        chk("R7 col on", col_en, 1);
        ras_n = 1'b1; step();
        chk("R7 col off", col_en, 0);
        chk("R6 cnt", cnt_value, exp_cnt);
        cas_n = 1'b1; step();
    endtask

    task automatic t_cbr(input int junk);
        precharge();
        cas_n = 1'b0; step();
        row_addr = RW'(junk); ras_n = 1'b0; step();
        chk("R3 rfsh", refresh_only, 1);
        chk("R3 row", row_sel, exp_cnt);
        chk("R7 col in rfsh", col_en, 0);
        step();
        ras_n = 1'b1; step();
        exp_cnt = (exp_cnt + 1) % 512;
        chk("R5 adv", cnt_value, exp_cnt);
        chk("R5 rfsh drop", refresh_only, 0);
        cas_n = 1'b1; step();
    endtask

    task automatic t_simul(input int a);
        precharge();
        row_addr = RW'(a); cas_n = 1'b0; ras_n = 1'b0; step();
        chk("R4 simul rfsh", refresh_only, 0);
        chk("R4 simul row", row_sel, a);
        ras_n = 1'b1; step();
        chk("R4 simul cnt", cnt_value, exp_cnt);
        cas_n = 1'b1; step();
    endtask

    task automatic t_held(input int a);
        precharge();
        row_addr = '0; ras_n = 1'b0; step();
        cas_n = 1'b0; step();
        ras_n = 1'b1; step(); step();
        row_addr = RW'(a); ras_n = 1'b0; step();
        chk("R4 held rfsh", refresh_only, 0);
        chk("R4 held row", row_sel, a);
        ras_n = 1'b1; cas_n = 1'b1; step();
        precharge();
        cas_n = 1'b0; step();
        cas_n = 1'b1; step();
        row_addr = RW'(a ^ 3); ras_n = 1'b0; step();
        chk("R4 cancel rfsh", refresh_only, 0);
        chk("R4 cancel row", row_sel, a ^ 3);
        ras_n = 1'b1; step();
    endtask

    task automatic t_test_mode();
        precharge();
        cas_n = 1'b0; step();
        row_addr = 9'h0AA; ras_n = 1'b0; step();
        cas_n = 1'b1; step();
        chk("R8 still rfsh", refresh_only, 1);
        cas_n = 1'b0; step();
        chk("R8 test", ctr_test, 1);
        chk("R8 rfsh off", refresh_only, 0);
        chk("R8 col", col_en, 1);
        chk("R8 row", row_sel, exp_cnt);
        chk("R8 no early adv", cnt_value, exp_cnt);
        ras_n = 1'b1; cas_n = 1'b1; step();
        exp_cnt = (exp_cnt + 1) % 512;
        chk("R8 adv once", cnt_value, exp_cnt);
        chk("R8 test drop", ctr_test, 0);
    endtask

    task automatic t_wrap();
        while (exp_cnt != 511) begin
            ras_n = 1'b1; cas_n = 1'b1; step();
            cas_n = 1'b0; step();
            ras_n = 1'b0; step();
            ras_n = 1'b1; step();
            exp_cnt++;
        end
        chk("R5 at 511", cnt_value, 511);
        t_cbr(5);
        chk("R5 wrap", cnt_value, 0);
    endtask

    initial begin
        #1600000;
        n_bad++;
        $display("FAIL watchdog: actual running expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_normal(9'h123);
        t_normal(9'h1FF);
        t_cbr(9'h155);
        t_cbr(9'h0F0);
        t_simul(9'h077);
        t_held(9'h1C4);
        t_test_mode();
        t_normal(9'h001);
        t_wrap();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule